// File: doc/BRIEF.md
# Triggered Acquisition Conversion Controller

This block decides when an analog-to-digital converter receives a conversion strobe during a multi-sample acquisition. Two sources can request a conversion: an internal interval counter that paces samples at a programmed divisor, and an active-low external convert input. A single gate flag enables or blocks both sources together. A sample counter closes the gate once a programmed number of conversions has been taken.

Software configures the block with one register write. That write loads the divisor and the sample count, selects the trigger mode, and re-arms the trigger. In posttrigger mode the gate stays shut until the external trigger rises. In pretrigger mode, conversions start at once. The sample counter then stays frozen until the trigger edge, after which exactly the programmed number of further samples is taken.

In freerun mode the sample counter is ignored, and conversions continue until software clears the gate. Both external inputs are asynchronous. Each passes through a synchronizer chain before its edge is detected.

Top module: `acq_conv_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `conv_strobe`, `busy` and `done` are low. No strobe occurs before the first configuration write.
- R2: With the gate open, the interval counter yields one strobe every D cycles, where D is `cfg_divisor`. The first strobe comes D cycles after the configuration write. D = 0 means 2^DIV_W cycles.
- R3: A high-to-low transition on `ext_conv_n` produces exactly one strobe while the gate is open. The strobe appears three clock edges after the input changes (two synchronizer stages plus the edge register). A low-to-high transition produces none.
- R4: While `busy` is low, neither the interval counter nor `ext_conv_n` produces a strobe.
- R5: In posttrigger mode (`cfg_ext_trig_en`=1, `cfg_pretrig`=0), `busy` stays low after the configuration write. It rises only after a synchronized rising edge of `ext_trig`.
- R6: In pretrigger mode (`cfg_pretrig`=1), `busy` rises with the configuration write and paced strobes begin at once. Strobes before the trigger edge take effect do not decrement the sample counter. After the trigger, exactly N counted strobes are issued and the gate closes.
- R7: When both `cfg_pretrig` and `cfg_ext_trig_en` are set, pretrigger behaviour applies.
- R8: In controlled mode (`cfg_freerun`=0), the strobe that takes the count from 1 to 0 also sets `done` and drops `busy`. A sample count of 0 means 2^CNT_W samples.
- R9: `done` stays set until the next configuration write, which clears it. While `done` is set, the gate cannot be reopened.
- R10: In freerun mode the sample count is ignored. Strobes continue until `sw_stop` drops `busy`, and `done` never sets.
- R11: Only the first rising edge of `ext_trig` after a configuration write is acted on. Later edges in the same acquisition have no effect.
- R12: A configuration write with neither `cfg_pretrig` nor `cfg_ext_trig_en` set leaves the gate shut, so no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_ext_trig_en | input | 1 | Enable posttrigger start on the external trigger |
| cfg_pretrig | input | 1 | Pretrigger mode; takes precedence over cfg_ext_trig_en |
| cfg_freerun | input | 1 | 1 = freerun, 0 = controlled by the sample counter |
| cfg_divisor | input | DIV_W | Interval counter divisor (0 = 2^DIV_W) |
| cfg_samples | input | CNT_W | Sample count (0 = 2^CNT_W) |
| sw_stop | input | 1 | Software request to clear the gate |
| ext_trig | input | 1 | Asynchronous external trigger, active on rising edge |
| ext_conv_n | input | 1 | Asynchronous active-low external convert request |
| conv_strobe | output | 1 | Single-cycle conversion strobe |
| busy | output | 1 | Gate state: conversions enabled |
| done | output | 1 | Sticky end-of-acquisition flag |

## Verification
The bench builds the block with a 4-bit divisor, a 4-bit sample count and two synchronizer stages. At that size, the zero-means-maximum encodings (16-cycle periods and 16-sample acquisitions) fit into short runs. A behavioural model, built from integers and a queue per synchronizer, predicts strobe, busy and done every cycle.

Directed windows then count strobes in several situations:
- posttrigger, pretrigger and combined-bit acquisitions;
- freerun stops;
- gated-off external requests;
- repeated trigger edges.

// File: rtl/acq_pkg.sv
package acq_pkg;

   // Mode selection latched at each configuration write
   typedef struct packed {
      logic trig_start;   // gate opens on trigger edge
      logic pre;          // pretrigger: gate opens at write, counter waits for trigger
      logic free;         // ignore the sample counter
   } acq_mode_t;

   localparam int unsigned ACQ_MIN_SYNC = 2;

endpackage

// File: rtl/acq_sync_edge.sv
module acq_sync_edge #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RISE    = 1'b1,
   parameter bit          IDLE_LV = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic pulse
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < acq_pkg::ACQ_MIN_SYNC) begin : g_bad_stages
      $error("acq_sync_edge: STAGES must be at least 2");
   end

   // chain[0..LAST] synchronizer, chain[STAGES] previous synchronized value
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES + 1){IDLE_LV}};
      else        chain <= {chain[STAGES-1:0], din};
   end

   if (RISE) begin : g_rise
      assign pulse = chain[LAST] & ~chain[STAGES];
   end else begin : g_fall
      assign pulse = ~chain[LAST] & chain[STAGES];
   end

endmodule

// File: rtl/acq_interval_ctr.sv
module acq_interval_ctr #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] divisor,
   output logic         tick
);
   localparam logic [W-1:0] ONE = W'(1);

   if (W < 1) begin : g_bad_w
      $error("acq_interval_ctr: W must be positive");
   end

   logic [W-1:0] cnt_q;
   logic [W-1:0] div_q;
   logic         run_q;

   assign tick = run_q && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= divisor;
         div_q <= divisor;
         run_q <= 1'b1;
      end else if (run_q) begin
         // zero wraps to all ones, so a zero divisor spans 2^W cycles
         cnt_q <= tick ? div_q : cnt_q - ONE;
      end
   end

endmodule

// File: rtl/acq_sample_ctr.sv
module acq_sample_ctr #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] count,
   input  logic         dec,
   output logic         last
);
   localparam logic [W-1:0] ONE = W'(1);

   if (W < 1) begin : g_bad_w
      $error("acq_sample_ctr: W must be positive");
   end

   logic [W-1:0] rem_q;

   assign last = (rem_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rem_q <= '0;
      else if (load)   rem_q <= count;
      else if (dec)    rem_q <= rem_q - ONE;
   end

endmodule

// File: rtl/acq_conv_ctrl.sv
module acq_conv_ctrl #(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             cfg_ext_trig_en,
   input  logic             cfg_pretrig,
   input  logic             cfg_freerun,
   input  logic [DIV_W-1:0] cfg_divisor,
   input  logic [CNT_W-1:0] cfg_samples,
   input  logic             sw_stop,
   input  logic             ext_trig,
   input  logic             ext_conv_n,
   output logic             conv_strobe,
   output logic             busy,
   output logic             done
);
   import acq_pkg::*;

   if (SYNC_STAGES < ACQ_MIN_SYNC) begin : g_bad_sync
      $error("acq_conv_ctrl: SYNC_STAGES below minimum");
   end

   acq_mode_t mode_q;
   logic      mode_free_q;
   logic      gate_q, armed_q, cnt_run_q, term_q, strobe_q;
   logic      trig_rise, conv_fall, tick, last;
   logic      fire, cnt_active, dec, term;

   acq_sync_edge #(.STAGES(SYNC_STAGES), .RISE(1'b1), .IDLE_LV(1'b0)) u_trig (
      .clk(clk), .rst_n(rst_n), .din(ext_trig), .pulse(trig_rise));

   acq_sync_edge #(.STAGES(SYNC_STAGES), .RISE(1'b0), .IDLE_LV(1'b1)) u_conv (
      .clk(clk), .rst_n(rst_n), .din(ext_conv_n), .pulse(conv_fall));

   acq_interval_ctr #(.W(DIV_W)) u_interval (
      .clk(clk), .rst_n(rst_n), .load(cfg_wr), .divisor(cfg_divisor), .tick(tick));

   // conversion requested by either source, passed only through the gate
   assign fire       = gate_q & (tick | conv_fall);
   // pretrigger holds the sample counter until the trigger edge arrives
   assign cnt_active = mode_q.pre ? cnt_run_q : 1'b1;
   assign dec        = fire & cnt_active & ~mode_q.free;
   assign term       = dec & last;

   acq_sample_ctr #(.W(CNT_W)) u_samples (
      .clk(clk), .rst_n(rst_n), .load(cfg_wr), .count(cfg_samples), .dec(dec), .last(last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= '0;
         gate_q    <= 1'b0;
         armed_q   <= 1'b0;
         cnt_run_q <= 1'b0;
         term_q    <= 1'b0;
      end else if (cfg_wr) begin
         mode_q.trig_start <= cfg_ext_trig_en & ~cfg_pretrig;
         mode_q.pre        <= cfg_pretrig;
         mode_q.free       <= cfg_freerun;
         gate_q            <= cfg_pretrig;
         armed_q           <= cfg_pretrig | cfg_ext_trig_en;
         cnt_run_q         <= 1'b0;
         term_q            <= 1'b0;
      end else begin
         if (term) begin
            term_q <= 1'b1;
            gate_q <= 1'b0;
         end else if (sw_stop) begin
            gate_q <= 1'b0;
         end else if (trig_rise && armed_q && !term_q) begin
            if (mode_q.pre)             cnt_run_q <= 1'b1;
            else if (mode_q.trig_start) gate_q    <= 1'b1;
         end
         if (trig_rise) armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= fire;
   end

   assign mode_free_q = mode_q.free;
   assign conv_strobe = strobe_q;
   assign busy        = gate_q;
   assign done        = term_q;

endmodule

// File: rtl/acq_conv_ctrl_chk.sv
module acq_conv_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_wr,
   input logic conv_strobe,
   input logic busy,
   input logic done,
   input logic free_q,
   input logic trig_pulse
);

   AST_STROBE_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_strobe |-> $past(busy)); // R4

   AST_DONE_SHUTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R8

   AST_DONE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> conv_strobe); // R8

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cfg_wr) |=> done); // R9

   AST_FREERUN_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      free_q |-> !done); // R10

   AST_GATE_OPEN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(cfg_wr) || $past(trig_pulse))); // R5

endmodule

bind acq_conv_ctrl acq_conv_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .conv_strobe(conv_strobe),
   .busy(busy), .done(done), .free_q(mode_free_q), .trig_pulse(trig_rise));

// File: tb/acq_conv_ctrl_tb_top.sv
module acq_conv_ctrl_tb_top;
   localparam int DW = 4;
   localparam int CW = 4;
   localparam int DMASK = (1 << DW) - 1;
   localparam int CMASK = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0, cfg_ext_trig_en = 1'b0, cfg_pretrig = 1'b0, cfg_freerun = 1'b0;
   logic [DW-1:0] cfg_divisor = '0;
   logic [CW-1:0] cfg_samples = '0;
   logic sw_stop = 1'b0, ext_trig = 1'b0, ext_conv_n = 1'b1;
   logic conv_strobe, busy, done;

   int checks = 0, errors = 0, cyc = 0;
   bit started = 0;

   always #4 clk = ~clk;

   acq_conv_ctrl #(.DIV_W(DW), .CNT_W(CW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ext_trig_en(cfg_ext_trig_en),
      .cfg_pretrig(cfg_pretrig), .cfg_freerun(cfg_freerun), .cfg_divisor(cfg_divisor),
      .cfg_samples(cfg_samples), .sw_stop(sw_stop), .ext_trig(ext_trig),
      .ext_conv_n(ext_conv_n), .conv_strobe(conv_strobe), .busy(busy), .done(done));

   // behavioural reference model
   int tq[$];
   int cq[$];
   int m_icnt = 0, m_div = 0, m_rem = 0;
   bit m_run = 0, m_gate = 0, m_armed = 0, m_cen = 0, m_tc = 0, m_str = 0;
   bit m_pre = 0, m_ten = 0, m_free = 0;

   initial begin
      tq = '{0, 0, 0};
      cq = '{1, 1, 1};
   end

   always @(posedge clk) begin
      bit rise, fall, tick, fire, active, dec, term;
      if (!rst_n) begin
         tq = '{0, 0, 0}; cq = '{1, 1, 1};
         m_icnt = 0; m_div = 0; m_rem = 0; m_run = 0; m_gate = 0; m_armed = 0;
         m_cen = 0; m_tc = 0; m_str = 0; m_pre = 0; m_ten = 0; m_free = 0;
      end else begin
         // tq[0]=newest sync stage, tq[1]=synced, tq[2]=previous
         rise = (tq[1] == 1) && (tq[2] == 0);
         fall = (cq[1] == 0) && (cq[2] == 1);
         tick = m_run && (m_icnt == 1);
         fire = m_gate && (tick || fall);
         active = m_pre ? m_cen : 1'b1;
         dec = fire && active && !m_free;
         term = dec && (m_rem == 1);
         m_str = fire;
         if (cfg_wr) begin
            m_icnt = cfg_divisor; m_div = cfg_divisor; m_run = 1;
            m_rem = cfg_samples;
            m_pre = cfg_pretrig; m_ten = cfg_ext_trig_en; m_free = cfg_freerun;
            m_gate = cfg_pretrig; m_armed = cfg_pretrig || cfg_ext_trig_en;
            m_cen = 0; m_tc = 0;
         end else begin
            if (m_run) m_icnt = tick ? m_div : ((m_icnt - 1) & DMASK);
            if (dec) m_rem = (m_rem - 1) & CMASK;
            if (term) begin
               m_tc = 1; m_gate = 0;
            end else if (sw_stop) begin
               m_gate = 0;
            end else if (rise && m_armed && !m_tc) begin
               if (m_pre) m_cen = 1;
               else if (m_ten) m_gate = 1;
            end
            if (rise) m_armed = 0;
         end
         void'(tq.pop_back()); tq.push_front(int'(ext_trig));
         void'(cq.pop_back()); cq.push_front(int'(ext_conv_n));
      end
   end

   // every-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (started) begin
         checks++;
         if (conv_strobe !== m_str) begin
            errors++;
            $display("FAIL R2/R3 strobe at cycle %0d: actual %b expected %b", cyc, conv_strobe, m_str);
         end
         checks++;
         if (busy !== m_gate) begin
            errors++;
            $display("FAIL R5/R6 busy at cycle %0d: actual %b expected %b", cyc, busy, m_gate);
         end
         checks++;
         if (done !== m_tc) begin
            errors++;
            $display("FAIL R8/R9 done at cycle %0d: actual %b expected %b", cyc, done, m_tc);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired: actual %0d cycles expected below 20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic configure(input bit ten, input bit pre, input bit free,
                            input int div, input int n);
      @(negedge clk);
      cfg_ext_trig_en = ten; cfg_pretrig = pre; cfg_freerun = free;
      cfg_divisor = DW'(div); cfg_samples = CW'(n); cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic count_strobes(input int w, output int n);
      n = 0;
      for (int i = 0; i < w; i++) begin
         @(negedge clk);
         if (conv_strobe) n++;
      end
   endtask

   task automatic pulse_trig();
      ext_trig = 1'b1;
      repeat (4) @(negedge clk);
      ext_trig = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check("R1 strobe in reset", conv_strobe, 0);
      check("R1 busy in reset", busy, 0);
      check("R1 done in reset", done, 0);
      rst_n = 1'b1;
      started = 1;
      count_strobes(10, n);
      check("R1 no strobe before configuration", n, 0);

      // R12: neither trigger bit, gate remains shut
      configure(0, 0, 0, 3, 5);
      count_strobes(20, n);
      check("R12 no strobes without trigger bits", n, 0);
      check("R12 busy low", busy, 0);

      // R2 R10: freerun pretrigger, divisor 3
      configure(0, 1, 1, 3, 2);
      count_strobes(30, n);
      check("R2 paced strobes at divisor 3", n, 10);
      check("R10 freerun ignores count, busy", busy, 1);
      check("R10 done stays low", done, 0);
      sw_stop = 1'b1; @(negedge clk); sw_stop = 1'b0;
      check("R10 sw_stop closes gate", busy, 0);
      ext_conv_n = 1'b0;
      count_strobes(12, n);
      ext_conv_n = 1'b1;
      check("R4 no strobes with gate closed", n, 0);
      count_strobes(4, n);

      // R2: divisor 0 means 16
      configure(0, 1, 1, 0, 0);
      count_strobes(64, n);
      check("R2 zero divisor period 16", n, 4);

      // R3: external convert falling edge, divisor 0 keeps ticks out of the window
      configure(0, 1, 1, 0, 0);
      ext_conv_n = 1'b0;
      count_strobes(6, n);
      check("R3 one strobe per falling edge", n, 1);
      ext_conv_n = 1'b1;
      count_strobes(4, n);
      check("R3 rising edge gives no strobe", n, 0);
      sw_stop = 1'b1; @(negedge clk); sw_stop = 1'b0;

      // R5 R8 R9 R11: posttrigger controlled, divisor 2, three samples
      configure(1, 0, 0, 2, 3);
      count_strobes(10, n);
      check("R5 no strobes before trigger", n, 0);
      check("R5 busy low before trigger", busy, 0);
      ext_trig = 1'b1;
      count_strobes(30, n);
      check("R8 exactly N strobes after trigger", n, 3);
      check("R8 done set", done, 1);
      check("R8 busy dropped", busy, 0);
      ext_trig = 1'b0;
      repeat (4) @(negedge clk);
      pulse_trig();
      count_strobes(10, n);
      check("R11 later trigger edge ignored, strobes", n, 0);
      check("R9 done sticky", done, 1);
      check("R9 gate stays shut", busy, 0);
      configure(1, 0, 0, 2, 3);
      check("R9 configuration write clears done", done, 0);

      // R6 R7: both bits set, pretrigger rules, divisor 2, four samples
      configure(1, 1, 0, 2, 4);
      count_strobes(20, n);
      check("R6 R7 strobes before trigger", n, 10);
      check("R6 count frozen before trigger", done, 0);
      // trigger reaches the counter 3 edges later: strobes at +22 (uncounted), +24..+30 (counted)
      ext_trig = 1'b1;
      count_strobes(40, n);
      check("R6 N counted strobes after trigger plus one in flight", n, 5);
      check("R6 done after pretrigger acquisition", done, 1);
      ext_trig = 1'b0;

      // R8: sample count 0 means 16, divisor 1
      configure(1, 0, 0, 1, 0);
      ext_trig = 1'b1;
      count_strobes(40, n);
      check("R8 zero count gives 16 samples", n, 16);
      check("R8 done after zero count", done, 1);
      ext_trig = 1'b0;
      repeat (5) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule